// File: doc/BRIEF.md
# Masked Output Sequencer

This block steps through a small table of words and drives one word at a time onto a registered output. Each rising edge of the advance input moves a position pointer to its next entry. The word found there is merged into the output through a mask, so only the bits selected by the mask change. After the last entry selected by the length input, the pointer returns to entry 1. Entry 0 therefore acts as a starting pattern. It reaches the output only when the advance input is already high in the first cycle after reset.

The table is filled in two ways. A direct write port takes an address and data. A load strobe instead moves the pointer one step and stores a word at the new position, which lets a host record a list one step at a time. A combinational compare output reports whether an external word matches the current entry. Only the bits selected by a separate compare mask take part. The surrounding logic decides when to advance, for example from a timer.

Top module: `mask_step_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, pos_o becomes 0 and out_o becomes all zeros.
- R2: The pointer and the output react only to a 0-to-1 change of adv_i seen at a clock edge. Holding adv_i high leaves pos_o and out_o unchanged. After reset the previous level of adv_i counts as 0.
- R3: On an advance the pointer moves to pos_o+1 while pos_o is below len_i. Otherwise it moves to 1. With len_i = 4 the pointer visits 1,2,3,4,1,...
- R4: An advance in the first clock after reset is released sends entry 0 to the output and leaves pos_o at 0. If there is no advance in that clock, the first later advance goes to entry 1.
- R5: On an advance, out_o becomes (out_o & ~mask_i) | (entry & mask_i). With mask_i = 0x000F only bits 3..0 change.
- R6: In a cycle with no advance, out_o keeps its value whatever mask_i, the table or the other inputs do.
- R7: match_o is 1 exactly when cmp_data_i and the entry at pos_o agree in every bit where cmp_mask_i is 1. With cmp_mask_i = 0x0005 only bits 0 and 2 are compared.
- R8: A 0-to-1 change of ld_i moves the pointer with the same rule as R3 and writes ld_data_i into the entry at the new position. out_o is not changed.
- R9: A write-port access stores wr_data_i at wr_addr_i on the clock edge. An advance in the same edge that targets that address sends the old value. The table is not cleared by reset, and it accepts writes while reset is held.
- R10: When adv_i and ld_i both rise in the same cycle, the advance takes effect and the load is dropped: no table write occurs from it.
- R11: When a load and a write-port access fall in the same cycle, the load's write is performed and the write-port access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_i | input | 1 | Advance request, acted on at its rising edge |
| len_i | input | 4 | Index of the last entry in the cycle |
| mask_i | input | 16 | Output update mask |
| ld_i | input | 1 | Load request, acted on at its rising edge |
| ld_data_i | input | 16 | Word stored by a load |
| wr_en_i | input | 1 | Direct table write enable |
| wr_addr_i | input | 4 | Direct table write address |
| wr_data_i | input | 16 | Direct table write data |
| cmp_data_i | input | 16 | Word compared against the current entry |
| cmp_mask_i | input | 16 | Bits taking part in the compare |
| out_o | output | 16 | Registered masked output |
| pos_o | output | 4 | Current table position |
| match_o | output | 1 | Masked compare result |

## Verification
The hardest case to reach is the first-cycle activation of entry 0. The advance input must already be high on the very first edge after reset is released. Entry 0 must also hold a non-zero pattern, although reset has just been asserted. The stimulus writes the whole table through the write port while reset is still low, then releases reset with adv_i held high. A second reset later takes the other path, where the first advance arrives one cycle late and must land on entry 1. Same-cycle collisions are set up by computing the next target position in the bench and aiming the write port, the load and the advance at it in one cycle.

// File: rtl/seq_pkg.sv
// Shared types for the masked output sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package seq_pkg;
    // Kind of table step taken in a cycle
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_FIRST = 2'd1,
        EV_STEP  = 2'd2,
        EV_LOAD  = 2'd3
    } seq_ev_e;
endpackage

// File: rtl/seq_rise.sv
// Rising-edge detector for N independent level inputs.
// Assumes: inputs are synchronous to clk; the previous level is 0 after reset.
module seq_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    // Remember last sampled level of every input
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/seq_table.sv
// Word table with one write port and two combinational read ports.
// Assumes: DEPTH equals 2**AW so every address is in range; not reset.
module seq_table #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [W-1:0]  wd_i,
    input  logic [AW-1:0] ra0_i,
    output logic [W-1:0]  rd0_o,
    input  logic [AW-1:0] ra1_i,
    output logic [W-1:0]  rd1_o
);
    logic [W-1:0] mem [DEPTH];

    // Store one word per clock; new value readable from the next cycle
    always_ff @(posedge clk) begin
        if (we_i) mem[wa_i] <= wd_i;
    end

    assign rd0_o = mem[ra0_i];
    assign rd1_o = mem[ra1_i];

    // R9
    write_land_chk: assert property (@(posedge clk)
        we_i |=> (mem[$past(wa_i)] == $past(wd_i)));
endmodule

// File: rtl/seq_posctl.sv
// Position controller: chooses the event of the cycle and moves the pointer.
// Assumes: rises are single-cycle pulses from seq_rise; advance beats load.
module seq_posctl
    import seq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_rise_i,
    input  logic          ld_rise_i,
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] pos_o,
    output logic [AW-1:0] tgt_o,
    output seq_ev_e       ev_o
);
    logic [AW-1:0] pos_q;
    logic          first_q;
    logic [AW-1:0] step_tgt;

    // Next position of a normal step, wrapping back to entry 1
    always_comb begin
        if (pos_q >= len_i) step_tgt = AW'(1);
        else                step_tgt = pos_q + AW'(1);
    end

    // Pick this cycle's event; advance wins over load
    always_comb begin
        if (!rst_n)                     ev_o = EV_NONE;
        else if (adv_rise_i && first_q) ev_o = EV_FIRST;
        else if (adv_rise_i)            ev_o = EV_STEP;
        else if (ld_rise_i)             ev_o = EV_LOAD;
        else                            ev_o = EV_NONE;
    end

    assign tgt_o = (ev_o == EV_FIRST) ? '0 : step_tgt;

    // Pointer and first-activation flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            first_q <= 1'b1;
        end else begin
            first_q <= 1'b0;
            if (ev_o == EV_STEP || ev_o == EV_LOAD) pos_q <= step_tgt;
        end
    end

    assign pos_o = pos_q;

    // R3
    wrap_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_o == EV_STEP || ev_o == EV_LOAD) && pos_q >= len_i) |=> (pos_q == AW'(1)));
    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_o == EV_STEP || ev_o == EV_LOAD) && pos_q < len_i) |=> (pos_q == $past(pos_q) + AW'(1)));
    // R4
    first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |=> !first_q);
    // R4
    first_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_o == EV_FIRST) |=> (pos_q == '0));
endmodule

// File: rtl/mask_step_seq.sv
// Masked output sequencer top: edge detect, pointer, table, masked output, compare.
// Assumes: DEPTH is a power of two; all inputs synchronous to clk.
module mask_step_seq
    import seq_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic [AW-1:0] len_i,
    input  logic [W-1:0]  mask_i,
    input  logic          ld_i,
    input  logic [W-1:0]  ld_data_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [W-1:0]  cmp_data_i,
    input  logic [W-1:0]  cmp_mask_i,
    output logic [W-1:0]  out_o,
    output logic [AW-1:0] pos_o,
    output logic          match_o
);
    logic [1:0]    rise;
    seq_ev_e       ev;
    logic [AW-1:0] tgt;
    logic [AW-1:0] pos;
    logic          tw_en;
    logic [AW-1:0] tw_addr;
    logic [W-1:0]  tw_data;
    logic [W-1:0]  step_word;
    logic [W-1:0]  cur_word;
    logic [W-1:0]  out_q;

    seq_rise #(.N(2)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({ld_i, adv_i}),
        .rise_o (rise)
    );

    seq_posctl #(.AW(AW)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_rise_i (rise[0]),
        .ld_rise_i  (rise[1]),
        .len_i      (len_i),
        .pos_o      (pos),
        .tgt_o      (tgt),
        .ev_o       (ev)
    );

    // Share the single table write port; a load takes precedence
    always_comb begin
        if (ev == EV_LOAD) begin
            tw_en   = 1'b1;
            tw_addr = tgt;
            tw_data = ld_data_i;
        end else begin
            tw_en   = wr_en_i;
            tw_addr = wr_addr_i;
            tw_data = wr_data_i;
        end
    end

    seq_table #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_tab (
        .clk   (clk),
        .we_i  (tw_en),
        .wa_i  (tw_addr),
        .wd_i  (tw_data),
        .ra0_i (tgt),
        .rd0_o (step_word),
        .ra1_i (pos),
        .rd1_o (cur_word)
    );

    // Merge the stepped-to entry into the output under the mask
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (ev == EV_FIRST || ev == EV_STEP)
            out_q <= (out_q & ~mask_i) | (step_word & mask_i);
    end

    assign out_o   = out_q;
    assign pos_o   = pos;
    assign match_o = (((cmp_data_i ^ cur_word) & cmp_mask_i) == '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_q == '0 && pos == '0));
    // R5
    unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_FIRST || ev == EV_STEP) |=> (((out_q ^ $past(out_q)) & ~$past(mask_i)) == '0));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_NONE || ev == EV_LOAD) |=> $stable(out_q));
endmodule

// File: tb/test_mask_step_seq.sv
`timescale 1ns/1ps
module test_mask_step_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv_i, ld_i, wr_en_i;
    logic [3:0]  len_i, wr_addr_i, pos_o;
    logic [15:0] mask_i, ld_data_i, wr_data_i, cmp_data_i, cmp_mask_i, out_o;
    logic        match_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_tbl [16];
    int          m_pos;
    logic [15:0] m_out;
    bit          m_first, m_advp, m_ldp;

    always #2.5 clk = ~clk;

    mask_step_seq i_mask_step_seq (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .len_i(len_i), .mask_i(mask_i),
        .ld_i(ld_i), .ld_data_i(ld_data_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .cmp_data_i(cmp_data_i), .cmp_mask_i(cmp_mask_i),
        .out_o(out_o), .pos_o(pos_o), .match_o(match_o)
    );

    function automatic logic [15:0] merge(logic [15:0] o, logic [15:0] e, logic [15:0] m);
        return (o & ~m) | (e & m);
    endfunction

    function automatic int next_of(int p, int l);
        return (p >= l) ? 1 : p + 1;
    endfunction

    function automatic bit exp_match();
        return ((cmp_data_i ^ m_tbl[m_pos]) & cmp_mask_i) == 16'h0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic cyc(input string tag);
        bit ae, le;
        int tg;
        @(posedge clk);
        if (!rst_n) begin
            if (wr_en_i) m_tbl[wr_addr_i] = wr_data_i;
            m_pos = 0; m_out = 16'h0; m_first = 1; m_advp = 0; m_ldp = 0;
        end else begin
            ae = adv_i && !m_advp;
            le = ld_i && !m_ldp && !ae;
            tg = next_of(m_pos, int'(len_i));
            if (ae && m_first) m_out = merge(m_out, m_tbl[0], mask_i);
            else if (ae) begin
                m_out = merge(m_out, m_tbl[tg], mask_i);
                m_pos = tg;
            end else if (le) m_pos = tg;
            if (le) m_tbl[tg] = ld_data_i;
            else if (wr_en_i) m_tbl[wr_addr_i] = wr_data_i;
            m_first = 0; m_advp = adv_i; m_ldp = ld_i;
        end
        @(negedge clk);
        chk(tag, "pos_o", 32'(pos_o), 32'(m_pos));
        chk(tag, "out_o", 32'(out_o), 32'(m_out));
        chk(tag, "match_o", 32'(match_o), 32'(exp_match()));
    endtask

    task automatic idle_inputs();
        wr_en_i = 0; ld_i = 0; adv_i = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 0; adv_i = 0; ld_i = 0; wr_en_i = 0; len_i = 4'd4;
        mask_i = 16'hFFFF; ld_data_i = 0; wr_addr_i = 0; wr_data_i = 0;
        cmp_data_i = 0; cmp_mask_i = 0;
        for (int i = 0; i < 16; i++) m_tbl[i] = 16'h0;
        @(negedge clk);

        // fill table during reset (R9), outputs held clear (R1)
        for (int i = 0; i < 16; i++) begin
            wr_en_i = 1; wr_addr_i = 4'(i); wr_data_i = 16'h1000 * 16'(i % 16) + 16'h0111 * 16'(i) + 16'h0C0;
            cyc("R9");
        end
        wr_en_i = 0;
        cyc("R1");
        chk("R1", "pos_o reset", 32'(pos_o), 0);
        chk("R1", "out_o reset", 32'(out_o), 0);

        // first-cycle activation sends entry 0 (R4)
        adv_i = 1; rst_n = 1;
        cyc("R4");
        chk("R4", "out_o entry0", 32'(out_o), 32'(m_tbl[0]));
        chk("R4", "pos_o stays 0", 32'(pos_o), 0);
        // held level does nothing (R2)
        repeat (3) cyc("R2");
        chk("R2", "pos_o held", 32'(pos_o), 0);

        // stepping and wrap with low-nibble mask (R3, R5)
        mask_i = 16'h000F;
        for (int k = 0; k < 12; k++) begin
            adv_i = 0; cyc("R3");
            adv_i = 1; cyc("R5");
        end
        adv_i = 0; cyc("R3");

        // masked compare (R7)
        cmp_mask_i = 16'h0005;
        cmp_data_i = m_tbl[m_pos] ^ 16'hFFFA;
        cyc("R7");
        chk("R7", "match bits 0,2", 32'(match_o), 1);
        cmp_data_i = m_tbl[m_pos] ^ 16'h0004;
        cyc("R7");
        chk("R7", "mismatch bit 2", 32'(match_o), 0);

        // load step (R8), then read it back through the compare
        ld_data_i = 16'h5A5A; ld_i = 1;
        cyc("R8");
        ld_i = 0; cmp_mask_i = 16'hFFFF; cmp_data_i = 16'h5A5A;
        cyc("R8");
        chk("R8", "loaded word matches", 32'(match_o), 1);

        // write to the advance target in the same edge: old value used (R9)
        mask_i = 16'hFFFF;
        wr_en_i = 1; wr_addr_i = 4'(next_of(m_pos, int'(len_i))); wr_data_i = 16'hBEEF;
        adv_i = 1;
        cyc("R9");
        wr_en_i = 0; adv_i = 0; cmp_data_i = 16'hBEEF;
        cyc("R9");
        chk("R9", "new word visible", 32'(match_o), 1);

        // advance and load together: load dropped (R10)
        ld_data_i = 16'h0F0F; adv_i = 1; ld_i = 1;
        cyc("R10");
        adv_i = 0; ld_i = 0;
        cyc("R10");

        // load and write port together: write dropped (R11)
        wr_en_i = 1; wr_addr_i = 4'd0; wr_data_i = 16'h7777;
        ld_i = 1; ld_data_i = 16'h3C3C;
        cyc("R11");
        wr_en_i = 0; ld_i = 0;
        cyc("R11");

        // idle cycles with changing mask keep out_o (R6)
        for (int k = 0; k < 6; k++) begin
            mask_i = 16'($urandom); wr_en_i = 1; wr_addr_i = 4'($urandom); wr_data_i = 16'($urandom);
            cyc("R6");
        end
        wr_en_i = 0;

        // second reset, late first advance goes to entry 1 (R4)
        rst_n = 0; adv_i = 0; cyc("R1");
        rst_n = 1; mask_i = 16'hFFFF; cyc("R4");
        adv_i = 1; cyc("R4");
        chk("R4", "late first advance pos", 32'(pos_o), 1);
        chk("R4", "late first advance out", 32'(out_o), 32'(m_tbl[1]));
        adv_i = 0; cyc("R4");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            adv_i   = ($urandom % 3) == 0;
            ld_i    = ($urandom % 9) == 0;
            ld_data_i = 16'($urandom);
            wr_en_i = ($urandom % 5) == 0;
            wr_addr_i = 4'($urandom); wr_data_i = 16'($urandom);
            if (($urandom % 50) == 0) len_i = 4'($urandom);
            mask_i  = (($urandom % 4) == 0) ? 16'h000F : 16'($urandom);
            cmp_mask_i = 16'($urandom);
            cmp_data_i = (($urandom % 2) == 0) ? m_tbl[m_pos] : 16'($urandom);
            cyc("R3 R5 R6 R7 R8");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule